// File: doc/BRIEF.md
# Nibble ALU with Substitution Operations

This block is a small arithmetic and logic unit for 4-bit operands. Each request carries two 4-bit two's-complement operands and a 3-bit operation select. The unit can add, subtract, shift left or right by one place, exclusive-or the operands, pass the first operand through unchanged, or look the first operand up in a fixed 4-bit substitution box or in that box's inverse. Besides the 4-bit result it produces two condition bits: one flags a zero result and one flags a negative result.

The datapath itself is purely combinational. It sits behind one register stage. A request is presented with `in_valid` high. One clock later the result and condition bits appear, and `out_valid` is high for that single cycle. Between requests the outputs keep the last captured values. This makes the unit easy to drop into a pipelined control path that needs substitution steps next to ordinary nibble arithmetic.

Top module: `nib_alu_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `res` and `cc` are cleared to 0.
- R2: When `in_valid` is high at a rising edge, `res`, `cc` and `out_valid`=1 appear after that edge. When `in_valid` is low at an edge, `out_valid` goes low and `res` and `cc` keep their values.
- R3: `op_sel`=0 gives `res` = (`op_a` + `op_b`) mod 16, and the carry is dropped.
- R4: `op_sel`=1 gives `res` = (`op_a` - `op_b`) mod 16.
- R5: `op_sel`=2 shifts `op_a` left by one place. Bit 3 is lost and bit 0 becomes 0.
- R6: `op_sel`=3 shifts `op_a` right by one place. Bit 3 becomes 0, so the shift is logical.
- R7: `op_sel`=4 gives `res` = `op_a` XOR `op_b`.
- R8: `op_sel`=5 gives `res` = `op_a`, and `op_b` has no effect on it.
- R9: `op_sel`=6 maps `op_a` through the substitution box. In hex the inputs 0 to F map to 9,4,A,B,D,1,8,5,6,2,0,3,C,E,F,7 in that order.
- R10: `op_sel`=7 applies the exact inverse of the R9 mapping, so that inverse(forward(x)) = x (for example, 9 maps to 0).
- R11: `cc[0]` is 1 exactly when the captured `res` is 0.
- R12: `cc[1]` is 1 exactly when the captured `res` is negative as a 4-bit two's-complement value, that is, when `res[3]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands are captured at this edge |
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| op_sel | input | 3 | Operation select, 0 to 7 |
| out_valid | output | 1 | High for one cycle when a new result is present |
| res | output | 4 | Registered result |
| cc | output | 2 | Condition bits: bit 0 is zero, bit 1 is negative |

## Verification
The hardest behaviour to exercise is the idle cycle. After a request, `in_valid` drops, and the bench must show that the result holds while operands of a different operation sit on the inputs. To get there, the bench drives conflicting operands and an opposite select during the idle cycle, and then confirms that `res` and `cc` still hold the previous result. The inverse box is also checked in both directions: every nibble goes forward and then back, so an error in any single entry of either table shows up.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int NIB_W = 4;
    localparam int SEL_W = 3;
    localparam int CC_W  = 2;
    localparam int NIB_N = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5,
        OP_SUBF = 3'd6,
        OP_SUBI = 3'd7
    } op_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } flags_t;

    typedef struct packed {
        nib_t   value;
        flags_t flags;
    } result_t;

    function automatic nib_t box_fwd(input nib_t x);
        nib_t y;
        case (x)
            4'h0: y = 4'h9;
            4'h1: y = 4'h4;
            4'h2: y = 4'hA;
            4'h3: y = 4'hB;
            4'h4: y = 4'hD;
            4'h5: y = 4'h1;
            4'h6: y = 4'h8;
            4'h7: y = 4'h5;
            4'h8: y = 4'h6;
            4'h9: y = 4'h2;
            4'hA: y = 4'h0;
            4'hB: y = 4'h3;
            4'hC: y = 4'hC;
            4'hD: y = 4'hE;
            4'hE: y = 4'hF;
            default: y = 4'h7;
        endcase
        return y;
    endfunction

    // Inverse derived by searching the forward map, so the two cannot drift apart.
    function automatic nib_t box_inv(input nib_t x);
        nib_t y;
        y = '0;
        for (int k = 0; k < NIB_N; k++) begin
            if (box_fwd(nib_t'(k)) == x) y = nib_t'(k);
        end
        return y;
    endfunction

endpackage

// File: rtl/nib_alu_box.sv
module nib_alu_box
    import nib_alu_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  nib_t din,
    output nib_t dout
);
    generate
        if (INVERSE) begin : g_inv
            assign dout = box_inv(din);
        end else begin : g_fwd
            assign dout = box_fwd(din);
        end
    endgenerate
endmodule

// File: rtl/nib_alu_flags.sv
module nib_alu_flags
    import nib_alu_pkg::*;
(
    input  nib_t   value,
    output flags_t flags
);
    always_comb begin
        flags.zero = (value == '0);
        flags.neg  = value[NIB_W-1];
    end
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
    import nib_alu_pkg::*;
(
    input  nib_t                a,
    input  nib_t                b,
    input  logic [SEL_W-1:0]    sel,
    output result_t             out
);
    nib_t   fwd_q;
    nib_t   inv_q;
    nib_t   value;
    flags_t flags;
    op_e    op;

    assign op = op_e'(sel);

    nib_alu_box #(.INVERSE(1'b0)) i_fwd (.din(a), .dout(fwd_q));
    nib_alu_box #(.INVERSE(1'b1)) i_inv (.din(a), .dout(inv_q));

    always_comb begin
        case (op)
            OP_ADD:  value = a + b;
            OP_SUB:  value = a - b;
            OP_SHL:  value = {a[NIB_W-2:0], 1'b0};
            OP_SHR:  value = {1'b0, a[NIB_W-1:1]};
            OP_XOR:  value = a ^ b;
            OP_PASS: value = a;
            OP_SUBF: value = fwd_q;
            default: value = inv_q;
        endcase
    end

    nib_alu_flags i_flags (.value(value), .flags(flags));

    assign out = '{value: value, flags: flags};
endmodule

// File: rtl/nib_alu_reg.sv
module nib_alu_reg
    import nib_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [NIB_W-1:0] op_a,
    input  logic [NIB_W-1:0] op_b,
    input  logic [SEL_W-1:0] op_sel,
    output logic             out_valid,
    output logic [NIB_W-1:0] res,
    output logic [CC_W-1:0]  cc
);
    result_t comb_r;
    result_t held_r;

    nib_alu_core i_core (.a(op_a), .b(op_b), .sel(op_sel), .out(comb_r));

    always_ff @(posedge clk) begin
        if (rst) begin
            held_r    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) held_r <= comb_r;
        end
    end

    assign res = held_r.value;
    assign cc  = {held_r.flags.neg, held_r.flags.zero};
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [NIB_W-1:0] op_a,
    input logic [NIB_W-1:0] op_b,
    input logic [SEL_W-1:0] op_sel,
    input logic             out_valid,
    input logic [NIB_W-1:0] res,
    input logic [CC_W-1:0]  cc
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && res == '0 && cc == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res) && $stable(cc)));

    // R7
    xor_res_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd4) |=> res == ($past(op_a) ^ $past(op_b)));

    // R8
    pass_res_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd5) |=> res == $past(op_a));

    // R3
    add_res_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0) |=> res == NIB_W'($past(op_a) + $past(op_b)));

    // R11
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cc[0] == (res == '0)));

    // R12
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cc[1] == res[NIB_W-1]));
endmodule

bind nib_alu_reg nib_alu_chk i_chk (.*);

// File: tb/test_nib_alu_reg.sv
`timescale 1ns/1ps
module test_nib_alu_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [3:0] op_a, op_b;
    logic [2:0] op_sel;
    logic       out_valid;
    logic [3:0] res;
    logic [1:0] cc;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nib_alu_reg i_nib_alu_reg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sel(op_sel), .out_valid(out_valid), .res(res), .cc(cc)
    );

    logic [3:0] tb_box [16];
    initial begin
        tb_box[0]=4'h9; tb_box[1]=4'h4; tb_box[2]=4'hA; tb_box[3]=4'hB;
        tb_box[4]=4'hD; tb_box[5]=4'h1; tb_box[6]=4'h8; tb_box[7]=4'h5;
        tb_box[8]=4'h6; tb_box[9]=4'h2; tb_box[10]=4'h0; tb_box[11]=4'h3;
        tb_box[12]=4'hC; tb_box[13]=4'hE; tb_box[14]=4'hF; tb_box[15]=4'h7;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request; outputs sampled at the negedge after the capturing edge.
    task automatic issue(input logic [3:0] a, input logic [3:0] b, input logic [2:0] s,
                         output logic [3:0] r, output logic [1:0] c);
        @(negedge clk);
        op_a = a; op_b = b; op_sel = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 out_valid high", out_valid, 1);
        r = res; c = cc;
    endtask

    function automatic logic [1:0] exp_cc(input logic [3:0] r);
        return {r[3], r == 4'h0};
    endfunction

    task automatic run_op(input string tag, input logic [3:0] a, input logic [3:0] b,
                          input logic [2:0] s, input logic [3:0] exp_r);
        logic [3:0] r; logic [1:0] c;
        issue(a, b, s, r, c);
        check(tag, r, exp_r);
        check("R11 zero flag", c[0], exp_cc(exp_r)[0]);
        check("R12 neg flag", c[1], exp_cc(exp_r)[1]);
    endtask

    task automatic test_reset;
        rst = 1'b1; in_valid = 1'b0; op_a = 4'hF; op_b = 4'hF; op_sel = 3'd0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 res", res, 0);
        check("R1 cc", cc, 0);
        rst = 1'b0;
    endtask

    task automatic test_add;
        run_op("R3 add", 4'd3, 4'd4, 3'd0, 4'd7);
        run_op("R3 add wrap", 4'hF, 4'h1, 3'd0, 4'h0);
        run_op("R3 add carry drop", 4'h9, 4'hA, 3'd0, 4'h3);
        run_op("R3 add neg", 4'h5, 4'h3, 3'd0, 4'h8);
    endtask

    task automatic test_sub;
        run_op("R4 sub", 4'd9, 4'd2, 3'd1, 4'd7);
        run_op("R4 sub borrow", 4'd2, 4'd3, 3'd1, 4'hF);
        run_op("R4 sub zero", 4'hA, 4'hA, 3'd1, 4'h0);
    endtask

    task automatic test_shifts;
        run_op("R5 shl drop msb", 4'hB, 4'h0, 3'd2, 4'h6);
        run_op("R5 shl", 4'h5, 4'hF, 3'd2, 4'hA);
        run_op("R6 shr logical", 4'h9, 4'h0, 3'd3, 4'h4);
        run_op("R6 shr msb set", 4'hF, 4'h0, 3'd3, 4'h7);
        run_op("R6 shr to zero", 4'h1, 4'h0, 3'd3, 4'h0);
    endtask

    task automatic test_logic;
        run_op("R7 xor", 4'hC, 4'hA, 3'd4, 4'h6);
        run_op("R7 xor same", 4'h7, 4'h7, 3'd4, 4'h0);
        run_op("R8 pass b0", 4'hD, 4'h0, 3'd5, 4'hD);
        run_op("R8 pass b ignored", 4'hD, 4'h6, 3'd5, 4'hD);
    endtask

    task automatic test_boxes;
        for (int k = 0; k < 16; k++) begin
            logic [3:0] f; logic [3:0] g; logic [1:0] c;
            issue(4'(k), 4'(15 - k), 3'd6, f, c);
            check("R9 forward box", f, tb_box[k]);
            check("R12 neg flag box", c[1], tb_box[k][3]);
            issue(f, 4'(k), 3'd7, g, c);
            check("R10 inverse box", g, k);
            check("R11 zero flag box", c[0], k == 0);
        end
        run_op("R10 inverse of 9", 4'h9, 4'h0, 3'd7, 4'h0);
    endtask

    task automatic test_idle;
        logic [3:0] r; logic [1:0] c;
        issue(4'h8, 4'h0, 3'd5, r, c);
        op_a = 4'h0; op_b = 4'h0; op_sel = 3'd1;
        @(negedge clk);
        check("R2 out_valid drops", out_valid, 0);
        check("R2 res held", res, 4'h8);
        check("R2 cc held", cc, 2'b10);
        @(negedge clk);
        check("R2 res still held", res, 4'h8);
    endtask

    initial begin
        fork
            begin
                test_reset;
                test_add;
                test_sub;
                test_shifts;
                test_logic;
                test_boxes;
                test_idle;
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule